// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, and the current pixel and line positions. Each line is made of four segments in a fixed order (sync pulse, back porch, active pixels, front porch), and the frame is made of the same four segments counted in lines. Every segment length is programmed as its count minus one. The counters advance on a clock-enable pulse. That pulse comes from the source clock, either directly at 1:1 or divided by a programmable ratio.

Scanning starts when the enable input is set. The enable, the divider settings and all segment lengths are taken into shadow registers. While the block is idle these registers follow their inputs on every cycle. While it is scanning they are reloaded only at the frame boundary, so a frame is never torn by a change made mid-frame. A polarity word selects active-high or active-low for each of the three strobes and applies at once. A frame event can be placed at the start of any vertical segment. It sets a pending bit, which a clear strobe resets, and the interrupt output is the pending bit gated by a global enable.

Top module: `lcd_tgen`

## Requirements
- R1: Within a line the pixel counter `hcnt_o` runs from 0 to total-1. Horizontal sync is active for the first hsw_i+1 pixel ticks, followed by hbp_i+1 back-porch ticks, hact_i+1 active ticks and hfp_i+1 front-porch ticks.
- R2: The line counter `vcnt_o` advances once at the end of each line and runs from 0 to total-1. Vertical sync is active for lines [0, vsw_i], followed by vbp_i+1 back-porch lines, vact_i+1 active lines and vfp_i+1 front-porch lines.
- R3: Data-enable is active only when both the pixel counter and the line counter are inside their active segments.
- R4: With div_en_i=0 the counters advance on every source clock. With div_en_i=1 they advance once every div_val_i+1 source clocks, so a frame lasts (line length × frame height × ratio) source clocks.
- R5: pol_i bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable, so a set bit makes that strobe active low. The polarity word applies immediately, and it applies to the idle level too.
- R6: en_i, div_en_i, div_val_i and every segment field are sampled on every cycle while the block is idle. While it is scanning they are sampled only on the last tick of the last line. Scanning begins at pixel 0, line 0 in the cycle after en_i is sampled high. After en_i is sampled low, the strobes are inactive and both counters read 0.
- R7: isel_i chooses the event line: 0 is the first sync line, 1 the first back-porch line, 2 the first active line and 3 the first front-porch line. When the line counter steps onto the chosen line with fie_i=1, pend_o goes high in the following cycle.
- R8: irq_o equals pend_o AND gie_i. pend_o holds until a cycle with iclr_i=1 clears it, and a new event in that same cycle takes priority over the clear.
- R9: After reset the strobes are inactive, both counters read 0, and pend_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scan enable (shadowed) |
| div_en_i | input | 1 | 1 selects divided pixel clock, 0 selects 1:1 |
| div_val_i | input | DIV_W | Divide ratio minus one |
| hsw_i | input | FIELD_W | Hsync width minus one |
| hbp_i | input | FIELD_W | Horizontal back porch minus one |
| hact_i | input | FIELD_W | Active pixels minus one |
| hfp_i | input | FIELD_W | Horizontal front porch minus one |
| vsw_i | input | FIELD_W | Vsync width in lines minus one |
| vbp_i | input | FIELD_W | Vertical back porch minus one |
| vact_i | input | FIELD_W | Active lines minus one |
| vfp_i | input | FIELD_W | Vertical front porch minus one |
| pol_i | input | 3 | Inversion bits: 0 hsync, 1 vsync, 2 data-enable |
| gie_i | input | 1 | Global interrupt enable |
| fie_i | input | 1 | Frame event enable |
| isel_i | input | 2 | Event line select |
| iclr_i | input | 1 | Clear pending (write-one strobe) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| hcnt_o | output | FIELD_W+2 | Pixel position in line |
| vcnt_o | output | FIELD_W+2 | Line position in frame |
| pend_o | output | 1 | Frame event pending |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. First, the divider value and bypass bit change only when the shadow registers reload them. Second, a clear and an event do not overlap unless the event is meant to win. Because of the shadowing, the stimulus can change the divider and the active width in the middle of a frame, and the check is that the running frame completes unchanged. All interrupt stimulus uses one small frame geometry, so the cycles at which events occur follow directly from R1, R2 and R7.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
  typedef enum logic [1:0] {
    EV_SYNC   = 2'd0,
    EV_BPORCH = 2'd1,
    EV_ACTIVE = 2'd2,
    EV_FPORCH = 2'd3
  } ev_sel_e;

  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_DE = 2;
  localparam int NPOL   = 3;
  localparam int NSEG   = 4;
endpackage

// File: rtl/lcd_tgen_clkdiv.sv
module lcd_tgen_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             byp_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ce_o
);
  logic [DIV_W-1:0] cnt_q;

  assign ce_o = run_i & (byp_i | (cnt_q == div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || ce_o || byp_i) cnt_q <= '0;
    else                          cnt_q <= cnt_q + DIV_W'(1);
  end

  // R4: in divided mode with ratio above one, ticks never fall in adjacent cycles
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o && !byp_i && div_i != '0 |=>
      !ce_o || div_i != $past(div_i) || byp_i != $past(byp_i));
endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis #(
  parameter int FW = 11,
  parameter int CW = FW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic [FW-1:0] sw_i,
  input  logic [FW-1:0] bp_i,
  input  logic [FW-1:0] act_i,
  input  logic [FW-1:0] fp_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          sync_o,
  output logic          act_o,
  output logic [3:0]    enter_o
);
  logic [CW-1:0] cnt_q, nxt;
  logic [CW-1:0] seg_start [4];
  logic [CW-1:0] total, last;

  always_comb begin
    seg_start[0] = '0;
    seg_start[1] = CW'(sw_i) + CW'(1);
    seg_start[2] = seg_start[1] + CW'(bp_i) + CW'(1);
    seg_start[3] = seg_start[2] + CW'(act_i) + CW'(1);
    total        = seg_start[3] + CW'(fp_i) + CW'(1);
    last         = total - CW'(1);
  end

  assign wrap_o = step_i & (cnt_q == last);
  assign nxt    = wrap_o ? '0 : cnt_q + CW'(1);
  assign sync_o = cnt_q < seg_start[1];
  assign act_o  = (cnt_q >= seg_start[2]) && (cnt_q < seg_start[3]);
  assign cnt_o  = cnt_q;

  for (genvar g = 0; g < 4; g++) begin : g_enter
    assign enter_o[g] = step_i & (nxt == seg_start[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= nxt;
  end

  // R1 R2: counter stays inside the programmed period
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < total);
  // R2: each step moves the position by exactly one
  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && step_i && !wrap_o |=> !run_i || cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/lcd_tgen_irq.sv
module lcd_tgen_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic fie_i,
  input  logic gie_i,
  input  logic clr_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, set_c;

  assign set_c  = ev_i & fie_i;
  assign pend_o = pend_q;
  assign irq_o  = pend_q & gie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_c) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  // R8: a clear with no competing event empties the pending bit
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_c |=> !pend_q);
  // R7: pending only rises after an enabled event
  a_r7_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(ev_i && fie_i));
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
#(
  parameter int FIELD_W = 11,
  parameter int DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               div_en_i,
  input  logic [DIV_W-1:0]   div_val_i,
  input  logic [FIELD_W-1:0] hsw_i,
  input  logic [FIELD_W-1:0] hbp_i,
  input  logic [FIELD_W-1:0] hact_i,
  input  logic [FIELD_W-1:0] hfp_i,
  input  logic [FIELD_W-1:0] vsw_i,
  input  logic [FIELD_W-1:0] vbp_i,
  input  logic [FIELD_W-1:0] vact_i,
  input  logic [FIELD_W-1:0] vfp_i,
  input  logic [2:0]         pol_i,
  input  logic               gie_i,
  input  logic               fie_i,
  input  logic [1:0]         isel_i,
  input  logic               iclr_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [FIELD_W+1:0] hcnt_o,
  output logic [FIELD_W+1:0] vcnt_o,
  output logic               pend_o,
  output logic               irq_o
);
  localparam int CW = FIELD_W + 2;

  typedef struct packed {
    logic [FIELD_W-1:0] sw;
    logic [FIELD_W-1:0] bp;
    logic [FIELD_W-1:0] act;
    logic [FIELD_W-1:0] fp;
  } axis_cfg_t;

  logic             run_q, divd_q;
  logic [DIV_W-1:0] div_q;
  axis_cfg_t        hcfg_q, vcfg_q;

  logic          ce, h_wrap, v_wrap, frame_wrap, load;
  logic          h_sync, h_act, v_sync, v_act;
  logic [3:0]    h_enter, v_enter;
  logic [CW-1:0] h_cnt, v_cnt;
  logic [NPOL-1:0] strobe;

  assign frame_wrap = h_wrap & v_wrap;
  assign load       = !run_q || frame_wrap;

  // shadow set: follows inputs while idle, reloads only at frame end while scanning
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      divd_q <= 1'b0;
      div_q  <= '0;
      hcfg_q <= '0;
      vcfg_q <= '0;
    end else if (load) begin
      run_q  <= en_i;
      divd_q <= div_en_i;
      div_q  <= div_val_i;
      hcfg_q <= '{sw: hsw_i, bp: hbp_i, act: hact_i, fp: hfp_i};
      vcfg_q <= '{sw: vsw_i, bp: vbp_i, act: vact_i, fp: vfp_i};
    end
  end

  lcd_tgen_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .byp_i  (!divd_q),
    .div_i  (div_q),
    .ce_o   (ce)
  );

  lcd_tgen_axis #(.FW(FIELD_W), .CW(CW)) i_haxis (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .step_i  (ce),
    .sw_i    (hcfg_q.sw),
    .bp_i    (hcfg_q.bp),
    .act_i   (hcfg_q.act),
    .fp_i    (hcfg_q.fp),
    .cnt_o   (h_cnt),
    .wrap_o  (h_wrap),
    .sync_o  (h_sync),
    .act_o   (h_act),
    .enter_o (h_enter)
  );

  lcd_tgen_axis #(.FW(FIELD_W), .CW(CW)) i_vaxis (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .step_i  (h_wrap),
    .sw_i    (vcfg_q.sw),
    .bp_i    (vcfg_q.bp),
    .act_i   (vcfg_q.act),
    .fp_i    (vcfg_q.fp),
    .cnt_o   (v_cnt),
    .wrap_o  (v_wrap),
    .sync_o  (v_sync),
    .act_o   (v_act),
    .enter_o (v_enter)
  );

  lcd_tgen_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (run_q & v_enter[isel_i]),
    .fie_i  (fie_i),
    .gie_i  (gie_i),
    .clr_i  (iclr_i),
    .pend_o (pend_o),
    .irq_o  (irq_o)
  );

  assign strobe[POL_HS] = run_q & h_sync;
  assign strobe[POL_VS] = run_q & v_sync;
  assign strobe[POL_DE] = run_q & h_act & v_act;

  logic [NPOL-1:0] pin;
  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    assign pin[p] = strobe[p] ^ pol_i[p];
  end

  assign hsync_o = pin[POL_HS];
  assign vsync_o = pin[POL_VS];
  assign de_o    = pin[POL_DE];
  assign hcnt_o  = h_cnt;
  assign vcnt_o  = v_cnt;

  // R6: shadowed divider holds for the whole frame
  a_r6_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !frame_wrap |=> $stable(div_q) && $stable(divd_q) && run_q);
  // R6: scanning always begins at the raster origin
  a_r6_start_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> h_cnt == '0 && v_cnt == '0);
endmodule

// File: tb/test_lcd_tgen.sv
`timescale 1ns/1ps
module test_lcd_tgen;
  localparam int FW = 11;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 0, div_en_i = 0, gie_i = 0, fie_i = 0, iclr_i = 0;
  logic [DW-1:0] div_val_i = '0;
  logic [FW-1:0] hsw_i = 1, hbp_i = 0, hact_i = 3, hfp_i = 0;
  logic [FW-1:0] vsw_i = 0, vbp_i = 0, vact_i = 2, vfp_i = 0;
  logic [2:0] pol_i = 3'b000;
  logic [1:0] isel_i = 2'd0;
  logic hsync_o, vsync_o, de_o, pend_o, irq_o;
  logic [FW+1:0] hcnt_o, vcnt_o;

  always #2 clk_i = ~clk_i;

  lcd_tgen #(.FIELD_W(FW), .DIV_W(DW)) i_lcd_tgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_en_i(div_en_i),
    .div_val_i(div_val_i), .hsw_i(hsw_i), .hbp_i(hbp_i), .hact_i(hact_i),
    .hfp_i(hfp_i), .vsw_i(vsw_i), .vbp_i(vbp_i), .vact_i(vact_i),
    .vfp_i(vfp_i), .pol_i(pol_i), .gie_i(gie_i), .fie_i(fie_i),
    .isel_i(isel_i), .iclr_i(iclr_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hcnt_o(hcnt_o), .vcnt_o(vcnt_o), .pend_o(pend_o),
    .irq_o(irq_o)
  );

  typedef struct {
    logic hs, vs, de;
    int   h, v;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int cyc = 0, t0 = 0;
  logic mon_on = 1'b0;
  logic timeout = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare one expected item per source clock
  always @(negedge clk_i) begin
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      mon_chk++;
      if (hsync_o !== e.hs || vsync_o !== e.vs || de_o !== e.de ||
          int'(hcnt_o) != e.h || int'(vcnt_o) != e.v) begin
        mon_fail++;
        $display("FAIL R1 R2 R3 R4 R5 R6 raster: actual hs=%b vs=%b de=%b h=%0d v=%0d expected hs=%b vs=%b de=%b h=%0d v=%0d",
                 hsync_o, vsync_o, de_o, hcnt_o, vcnt_o, e.hs, e.vs, e.de, e.h, e.v);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: expected raster per requirement R1..R5
  task automatic push_frame(input int hsw, hbp, ha, hfp, vsw, vbp, va, vfp,
                            input int ratio, input logic [2:0] pol);
    int htot = hsw + hbp + ha + hfp + 4;
    int vtot = vsw + vbp + va + vfp + 4;
    for (int v = 0; v < vtot; v++) begin
      for (int h = 0; h < htot; h++) begin
        for (int r = 0; r < ratio; r++) begin
          exp_t e;
          logic hs, vs, hact, vact;
          hs   = h < hsw + 1;
          vs   = v < vsw + 1;
          hact = (h >= hsw + hbp + 2) && (h < hsw + hbp + ha + 3);
          vact = (v >= vsw + vbp + 2) && (v < vsw + vbp + va + 3);
          e.hs = hs ^ pol[0];
          e.vs = vs ^ pol[1];
          e.de = (hact & vact) ^ pol[2];
          e.h  = h;
          e.v  = v;
          exp_q.push_back(e);
        end
      end
    end
  endtask

  task automatic push_idle(input int n, input logic [2:0] pol);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.hs = pol[0]; e.vs = pol[1]; e.de = pol[2]; e.h = 0; e.v = 0;
      exp_q.push_back(e);
    end
  endtask

  task automatic start_run();
    @(posedge clk_i); #1 en_i = 1'b1;
    @(posedge clk_i); #1 t0 = cyc;
  endtask

  task automatic at_cycle(input int k);
    @(negedge clk_i);
    while (cyc - t0 != k) @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    @(posedge clk_i); #1 iclr_i = 1'b1;
    @(posedge clk_i); #1 iclr_i = 1'b0;
  endtask

  task automatic run_all();
    // R9 reset state
    #1;
    chk("R9 hsync", hsync_o, 0);
    chk("R9 vsync", vsync_o, 0);
    chk("R9 de", de_o, 0);
    chk("R9 hcnt", int'(hcnt_o), 0);
    chk("R9 vcnt", int'(vcnt_o), 0);
    chk("R9 pend", pend_o, 0);
    chk("R9 irq", irq_o, 0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R5 idle levels follow polarity
    pol_i = 3'b111;
    @(negedge clk_i);
    chk("R5 idle hsync inverted", hsync_o, 1);
    chk("R5 idle vsync inverted", vsync_o, 1);
    chk("R5 idle de inverted", de_o, 1);

    // scoreboard: 1:1 frame, then shadowed change to ratio 3 and wider active
    pol_i = 3'b101;
    push_frame(1, 0, 3, 0, 0, 0, 2, 0, 1, 3'b101);
    push_frame(1, 0, 5, 0, 0, 0, 2, 0, 3, 3'b101);
    push_idle(10, 3'b101);
    start_run();
    mon_on = 1'b1;
    at_cycle(3);
    div_en_i = 1'b1; div_val_i = 8'd2; hact_i = 11'd5;
    at_cycle(60);
    en_i = 1'b0;
    wait (exp_q.size() == 0);
    @(posedge clk_i); #1 mon_on = 1'b0;

    // interrupt phase, 8x6 raster at 1:1
    div_en_i = 1'b0; div_val_i = '0; hact_i = 11'd3; pol_i = 3'b000;
    gie_i = 1'b1; fie_i = 1'b1; isel_i = 2'd2;
    repeat (4) @(posedge clk_i);
    start_run();
    at_cycle(15);
    chk("R7 pend before active line", pend_o, 0);
    at_cycle(16);
    chk("R7 pend at active line", pend_o, 1);
    chk("R8 irq with gie", irq_o, 1);
    pulse_clr();
    gie_i = 1'b0;
    at_cycle(19);
    chk("R8 pend cleared", pend_o, 0);
    at_cycle(64);
    chk("R7 pend next frame", pend_o, 1);
    chk("R8 irq masked by gie", irq_o, 0);
    pulse_clr();
    fie_i = 1'b0; gie_i = 1'b1;
    at_cycle(120);
    chk("R7 no pend with fie clear", pend_o, 0);
    chk("R8 irq idle", irq_o, 0);
    at_cycle(121);
    fie_i = 1'b1; isel_i = 2'd0;
    at_cycle(143);
    chk("R7 pend before frame start", pend_o, 0);
    at_cycle(144);
    chk("R7 pend at frame start", pend_o, 1);
    chk("R8 irq at frame start", irq_o, 1);
    en_i = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end
endmodule